// File: doc/BRIEF.md
# Auto-Restart Fault Sequencer

This block supervises a switching power stage whose control supply sits on an external capacitor. A hysteretic comparator around that supply reports two digital flags: one when the supply has sagged below the lower threshold, one when it has climbed above the upper threshold. A third flag says whether the regulation loop is feeding current back into the controller. When the supply sags to the lower threshold with no feedback present, the block treats the loop as broken. It turns the power switch off, enters a low-current standby and cycles the supply between the two thresholds with a high-voltage charge source.

Each completed charge ramp advances a three-bit retry counter. The power switch may run only in the terminal state of that counter and only while the charge source is off. As a result, only one supply discharge in every eight carries switching activity, which limits dissipation during a persistent fault to roughly one eighth. If feedback is present during the switching window, the block returns to normal operation.

All inputs are asynchronous and pass through synchronizers. The threshold flags are edge-detected, so one crossing counts once however long its flag stays high. The block carries no data stream, so every pin is a plain level-sensitive control or status signal with no handshake.

Top module: `restart_sequencer`

## Requirements
- R1: While reset is asserted and on the first cycles after it, the counter reads 7 (its terminal state), the charge enable is 1, and both the switch enable and the standby flag are 0.
- R2: A rising upper-threshold crossing clears the charge enable. A rising lower-threshold crossing sets it when the block is in auto-restart or feedback is absent. In normal mode, a lower crossing that occurs while feedback is present leaves the charge enable unchanged.
- R3: The counter advances by exactly one, modulo 8, on a rising upper-threshold crossing that occurs in auto-restart while the charge enable is 1. In every other case it holds its value.
- R4: The switch enable is 1 exactly when the counter reads 7 and the charge enable is 0.
- R5: In normal mode, a rising lower-threshold crossing while feedback is absent puts the block into auto-restart and sets the charge enable, which forces the switch off.
- R6: The standby flag is 1 exactly when the block is in auto-restart and the switch enable is 0.
- R7: In auto-restart, the block returns to normal mode when feedback is present, the counter reads 7 and the charge enable is 0. In normal mode the counter stays at 7.
- R8: With feedback absent, a run of alternating lower and upper crossings in auto-restart enables the switch after exactly one upper crossing in every eight.
- R9: Each threshold flag is synchronized over two flops and edge-detected. A flag held high for many cycles has the effect of a single crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| supply_low_i | input | 1 | Asynchronous flag: supply below the lower threshold |
| supply_high_i | input | 1 | Asynchronous flag: supply above the upper threshold |
| fb_present_i | input | 1 | Asynchronous flag: external feedback current present |
| sw_en_o | output | 1 | Power switch enable |
| chg_en_o | output | 1 | High-voltage charge source enable |
| standby_o | output | 1 | Low-current standby indication |
| cnt_o | output | 3 | Current retry counter state, 0 to 7 |

## Verification
On every cycle, the assertions check the following:
- the counter only steps by one, and only in the cycle the charge enable falls;
- the switch never runs while charging;
- the switch only turns on as a charge ramp ends;
- standby and switching exclude each other;
- normal mode pins the counter at its terminal state.

Other behaviour needs scenarios from the bench:
- the one-in-eight switching pattern over long retry runs;
- recovery once feedback returns;
- the case where a lower crossing with feedback present is ignored;
- the fact that a long-held flag counts once.

The bench covers these with directed sequences and a seeded random stream of crossings and feedback changes.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic {
    MODE_RUN     = 1'b0,
    MODE_RESTART = 1'b1
  } rs_mode_e;
endpackage

// File: rtl/rs_sync_edge.sv
module rs_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      last_q <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      last_q <= stage_q[STAGES-1];
    end
  end

  assign level_o = stage_q[STAGES-1];

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_edge
      assign rise_o[b] = stage_q[STAGES-1][b] & ~last_q[b];
    end
  endgenerate
endmodule

// File: rtl/rs_retry_cnt.sv
module rs_retry_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= TERM;
    else if (step_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o  = cnt_q;
  assign term_o = (cnt_q == TERM);
endmodule

// File: rtl/rs_mode_ctrl.sv
module rs_mode_ctrl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            low_rise_i,
  input  logic            high_rise_i,
  input  logic            fb_i,
  input  logic            term_i,
  output rs_pkg::rs_mode_e mode_o,
  output logic            chg_o,
  output logic            step_o
);
  import rs_pkg::*;

  rs_mode_e mode_q;
  logic     chg_q;
  logic     in_restart;
  logic     fault;
  logic     recover;

  assign in_restart = (mode_q == MODE_RESTART);
  assign fault      = !in_restart && low_rise_i && !fb_i;
  assign recover    = in_restart && fb_i && term_i && !chg_q;
  assign step_o     = in_restart && high_rise_i && chg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      chg_q  <= 1'b1;
    end else begin
      if (fault)        mode_q <= MODE_RESTART;
      else if (recover) mode_q <= MODE_RUN;

      if (high_rise_i)                                chg_q <= 1'b0;
      else if (low_rise_i && (in_restart || !fb_i))   chg_q <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/restart_sequencer.sv
module restart_sequencer #(
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_low_i,
  input  logic             supply_high_i,
  input  logic             fb_present_i,
  output logic             sw_en_o,
  output logic             chg_en_o,
  output logic             standby_o,
  output logic [CNT_W-1:0] cnt_o
);
  import rs_pkg::*;

  localparam int FLAG_LOW  = 0;
  localparam int FLAG_HIGH = 1;
  localparam int FLAG_FB   = 2;
  localparam int N_FLAGS   = 3;

  logic [N_FLAGS-1:0] flag_lvl;
  logic [N_FLAGS-1:0] flag_rise;
  rs_mode_e           mode_q;
  logic               chg_q;
  logic               step;
  logic               term;

  rs_sync_edge #(.WIDTH(N_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({fb_present_i, supply_high_i, supply_low_i}),
    .level_o (flag_lvl),
    .rise_o  (flag_rise)
  );

  rs_mode_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .low_rise_i  (flag_rise[FLAG_LOW]),
    .high_rise_i (flag_rise[FLAG_HIGH]),
    .fb_i        (flag_lvl[FLAG_FB]),
    .term_i      (term),
    .mode_o      (mode_q),
    .chg_o       (chg_q),
    .step_o      (step)
  );

  rs_retry_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step),
    .cnt_o  (cnt_o),
    .term_o (term)
  );

  assign chg_en_o  = chg_q;
  assign sw_en_o   = term && !chg_q;
  assign standby_o = (mode_q == MODE_RESTART) && !(term && !chg_q);
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_en,
  input logic             chg_en,
  input logic             standby,
  input logic [CNT_W-1:0] cnt,
  input logic             in_run
);
  localparam logic [CNT_W-1:0] TERM = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + ONE)); // R3
  AST_CNT_AT_CHG_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $fell(chg_en)); // R3
  AST_NO_SW_WHILE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !chg_en); // R4
  AST_SW_ON_AT_RAMP_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $fell(chg_en)); // R4
  AST_STANDBY_EXCL_SW: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sw_en); // R6
  AST_RUN_HOLDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (cnt == TERM)); // R7
  AST_RUN_NO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> !standby); // R6
endmodule

bind restart_sequencer rs_checker #(.CNT_W(CNT_W)) u_rs_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_en   (sw_en_o),
  .chg_en  (chg_en_o),
  .standby (standby_o),
  .cnt     (cnt_o),
  .in_run  (mode_q == rs_pkg::MODE_RUN)
);

// File: tb/restart_sequencer_tb_top.sv
module restart_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_low = 1'b0;
  logic       supply_high = 1'b0;
  logic       fb = 1'b0;
  logic       sw_en, chg_en, standby;
  logic [2:0] cnt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model
  bit       m_run = 1'b1;
  bit       m_chg = 1'b1;
  bit       m_fb  = 1'b0;
  bit [2:0] m_cnt = 3'd7;

  always #2 clk = ~clk;

  restart_sequencer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_low_i  (supply_low),
    .supply_high_i (supply_high),
    .fb_present_i  (fb),
    .sw_en_o       (sw_en),
    .chg_en_o      (chg_en),
    .standby_o     (standby),
    .cnt_o         (cnt)
  );

  function automatic bit exp_sw();
    return (m_cnt == 3'd7) && !m_chg;
  endfunction

  function automatic bit exp_standby();
    return !m_run && !exp_sw();
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " cnt"},     cnt,     m_cnt);
    chk({req, " chg_en"},  chg_en,  m_chg);
    chk({req, " sw_en"},   sw_en,   exp_sw());
    chk({req, " standby"}, standby, exp_standby());
  endtask

  function automatic void settle();
    if (!m_run && m_fb && m_cnt == 3'd7 && !m_chg) m_run = 1'b1;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ev_low(input int hold);
    supply_low = 1'b1;
    wait_cyc(hold);
    supply_low = 1'b0;
    wait_cyc(6);
    if (!m_run || !m_fb) begin
      m_chg = 1'b1;
      m_run = 1'b0;
    end
    settle();
  endtask

  task automatic ev_high(input int hold);
    supply_high = 1'b1;
    wait_cyc(hold);
    supply_high = 1'b0;
    wait_cyc(6);
    if (m_chg) begin
      if (!m_run) m_cnt = m_cnt + 3'd1;
      m_chg = 1'b0;
    end
    settle();
  endtask

  task automatic set_fb(input bit v);
    fb = v;
    wait_cyc(6);
    m_fb = v;
    settle();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sw_hits;
    int first_hit;
    void'($urandom(32'h0000_5EED));
    wait_cyc(5);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    wait_cyc(4);
    chk_all("R1 after reset");

    // power-up ramp ends, switching allowed at terminal state
    ev_high(3);
    chk_all("R2 R4 power-up");

    // long-held high flag counts once
    ev_high(40);
    chk_all("R9 held high flag");

    // fault entry
    ev_low(3);
    chk_all("R5 fault entry");
    chk("R5 standby", standby, 1);

    // sixteen retry cycles, one switching window in eight
    sw_hits = 0;
    first_hit = -1;
    for (int i = 0; i < 16; i++) begin
      ev_high(2 + (i % 5));
      chk_all("R3 retry ramp");
      if (sw_en) begin
        if (first_hit < 0) first_hit = i;
        else chk("R8 spacing", i - first_hit, 8);
        sw_hits++;
      end
      ev_low(2);
      chk_all("R6 discharge");
    end
    chk("R8 switching windows", sw_hits, 2);
    chk("R8 first window", first_hit, 7);

    // long-held low flag in restart counts once: counter unchanged
    ev_low(50);
    chk_all("R9 held low flag");

    // recovery: bring counter to 7 then assert feedback
    while (m_cnt != 3'd7 || m_chg) begin
      if (m_chg) ev_high(2); else ev_low(2);
    end
    chk_all("R4 terminal window");
    set_fb(1'b1);
    chk_all("R7 recovery");
    chk("R7 standby cleared", standby, 0);

    // lower crossing with feedback in normal mode is ignored
    ev_low(3);
    chk_all("R2 ignored low with feedback");
    chk("R2 chg stays off", chg_en, 0);

    // upper crossing in normal mode does not move counter
    ev_high(3);
    chk_all("R3 hold in normal");

    // feedback gone, fault again
    set_fb(1'b0);
    ev_low(2);
    chk_all("R5 second fault");

    // feedback during non-terminal states does not recover
    ev_high(2);
    set_fb(1'b1);
    chk_all("R7 no early recovery");
    set_fb(1'b0);

    // constrained random stream
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4)      ev_low(1 + int'($urandom % 8));
      else if (r < 8) ev_high(1 + int'($urandom % 8));
      else            set_fb(!m_fb);
      chk_all("R2 R3 R5 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule